// File: doc/BRIEF.md
# Termination Toggle Sequencer

This block sits on the controller side of a burst SRAM interface. It changes the memory's on-die termination enable input while the system runs. A typical use is to keep termination on during read and write traffic and to turn it off during long idle stretches to save power. A one-cycle request carries the wanted termination level. The block then runs a fixed sequence:

1. Hold the command path in no-operation so that accesses already in flight can finish.
2. Stop the input clock pair.
3. Flip the termination output while the clocks are stopped.
4. Restart the clocks.
5. Keep commands held for a relock wait, so that the memory's DLL can resynchronise before any new read or write.

When the sequence is over, a one-cycle done pulse is raised. A request whose level equals the present output level is finished at once: a done pulse is raised and the clocks are never touched. Requests that arrive while a sequence is running are dropped.

All outputs are registered. A single down-counter is reloaded for each timed phase, so the drain length, the clock-stopped hold and the relock wait are all parameters.

Top module: `odt_toggle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, cmd_hold=0, kclk_en=1, done=0 and odt_level equals the parameter ODT_RESET.
- R2: When req_valid=1 is sampled with req_level different from odt_level, cmd_hold is 1 from the next cycle on. kclk_en stays 1 for the first DRAIN_CYC cycles of that hold (the drain).
- R3: Directly after the drain, kclk_en is 0 for exactly 2*STOP_CYC+1 consecutive cycles.
- R4: odt_level changes only in a cycle where kclk_en is 0. It takes the requested level after the first STOP_CYC+1 stopped cycles and keeps that level through the remaining STOP_CYC stopped cycles.
- R5: After the clocks restart, cmd_hold stays 1 with kclk_en=1 for RELOCK_CYC cycles. In the cycle after that, cmd_hold drops to 0 and done is 1.
- R6: A request with req_level equal to odt_level gives done=1 in the next cycle, with cmd_hold=0, kclk_en=1 and odt_level unchanged.
- R7: Requests sampled while cmd_hold is 1 are ignored. The sequence timing and the final odt_level follow the accepted request only.
- R8: done is high for one cycle only, and never while cmd_hold is 1.
- R9: Level encoding: req_level and odt_level use 1 for termination enabled and 0 for termination disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_level | input | 1 | Wanted termination level, 1 = enabled |
| cmd_hold | output | 1 | Forces no-operation commands and blocks new traffic |
| kclk_en | output | 1 | Enable for the memory input clock pair, 0 = stopped |
| odt_level | output | 1 | Drive for the memory termination enable input |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions assume a synchronous reset. They also assume that req_level carries meaning only in a cycle where req_valid is high, so nothing is checked on req_level alone. The stimulus changes inputs only on falling clock edges. Each request strobe lasts a single cycle. Extra strobes of either level are placed inside running sequences, as well as directly after a done pulse, to show that requests are dropped while held and that back-to-back sequences still work.

// File: rtl/odt_seq_pkg.sv
package odt_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_CLK_STOP,
    ST_SWITCH,
    ST_CLK_RUN,
    ST_RELOCK
  } seq_state_t;
endpackage

// File: rtl/odt_seq_timer.sv
module odt_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/odt_seq_fsm.sv
module odt_seq_fsm
  import odt_seq_pkg::*;
#(
  parameter int   W          = 11,
  parameter int   DRAIN_CYC  = 4,
  parameter int   STOP_CYC   = 2,
  parameter int   RELOCK_CYC = 1024,
  parameter logic ODT_RESET  = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic         req_level,
  input  logic         tmr_zero,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         cmd_hold,
  output logic         kclk_en,
  output logic         odt_level,
  output logic         done
);
  localparam logic [W-1:0] DRAIN_LD  = W'(DRAIN_CYC - 1);
  localparam logic [W-1:0] STOP_LD   = W'(STOP_CYC - 1);
  localparam logic [W-1:0] RELOCK_LD = W'(RELOCK_CYC - 1);

  seq_state_t state, nxt;
  logic       target;
  logic       fin, quick;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    fin      = 1'b0;
    quick    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_level != odt_level) begin
            nxt      = ST_DRAIN;
            tmr_load = 1'b1;
            tmr_val  = DRAIN_LD;
          end else begin
            quick = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (tmr_zero) begin
          nxt      = ST_CLK_STOP;
          tmr_load = 1'b1;
          tmr_val  = STOP_LD;
        end
      end
      ST_CLK_STOP: begin
        if (tmr_zero) nxt = ST_SWITCH;
      end
      ST_SWITCH: begin
        nxt      = ST_CLK_RUN;
        tmr_load = 1'b1;
        tmr_val  = STOP_LD;
      end
      ST_CLK_RUN: begin
        if (tmr_zero) begin
          nxt      = ST_RELOCK;
          tmr_load = 1'b1;
          tmr_val  = RELOCK_LD;
        end
      end
      ST_RELOCK: begin
        if (tmr_zero) begin
          nxt = ST_IDLE;
          fin = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_hold  <= 1'b0;
      kclk_en   <= 1'b1;
      odt_level <= ODT_RESET;
      done      <= 1'b0;
      target    <= ODT_RESET;
    end else begin
      state    <= nxt;
      cmd_hold <= (nxt != ST_IDLE);
      kclk_en  <= !(nxt == ST_CLK_STOP || nxt == ST_SWITCH || nxt == ST_CLK_RUN);
      done     <= fin | quick;
      if (state == ST_IDLE && nxt == ST_DRAIN) target <= req_level;
      if (state == ST_SWITCH) odt_level <= target;
    end
  end

  // R4: the termination output moves only while the clocks are stopped
  assert_odt_moves_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(odt_level) |-> (!kclk_en && !$past(kclk_en)));

  // R2 / R3: clocks are only ever stopped inside a held sequence
  assert_stop_inside_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !kclk_en |-> cmd_hold);

  // R5: a restart of the clocks is followed by a held relock wait
  assert_restart_held_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(kclk_en) |-> cmd_hold);

  // R5: releasing the hold is announced by done
  assert_release_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_hold) |-> done);

  // R8: done never overlaps the hold
  assert_done_not_held_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_hold);

  // R8: done is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/odt_toggle_seq.sv
module odt_toggle_seq #(
  parameter int   DRAIN_CYC  = 4,
  parameter int   STOP_CYC   = 2,
  parameter int   RELOCK_CYC = 1024,
  parameter logic ODT_RESET  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_level,
  output logic cmd_hold,
  output logic kclk_en,
  output logic odt_level,
  output logic done
);
  localparam int MAX_A  = (DRAIN_CYC > STOP_CYC) ? DRAIN_CYC : STOP_CYC;
  localparam int MAX_C  = (MAX_A > RELOCK_CYC) ? MAX_A : RELOCK_CYC;
  localparam int TMR_W  = $clog2(MAX_C + 1);

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;

  odt_seq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  odt_seq_fsm #(
    .W          (TMR_W),
    .DRAIN_CYC  (DRAIN_CYC),
    .STOP_CYC   (STOP_CYC),
    .RELOCK_CYC (RELOCK_CYC),
    .ODT_RESET  (ODT_RESET)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_level (req_level),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .cmd_hold  (cmd_hold),
    .kclk_en   (kclk_en),
    .odt_level (odt_level),
    .done      (done)
  );

  initial begin
    assert (DRAIN_CYC >= 1 && STOP_CYC >= 1 && RELOCK_CYC >= 1)
      else $error("phase lengths must be at least one cycle");
  end
endmodule

// File: tb/test_odt_toggle_seq.sv
module test_odt_toggle_seq;
  localparam int   CLK_P = 10;
  localparam int   D     = 4;
  localparam int   S     = 2;
  localparam int   R     = 40;
  localparam logic ODT0  = 1'b1;

  typedef struct {
    logic  hold;
    logic  ce;
    logic  odt;
    logic  dn;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_level = 1'b0;
  logic cmd_hold, kclk_en, odt_level, done;

  exp_t sb[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic model_odt = ODT0;

  always #(CLK_P/2) clk = ~clk;

  odt_toggle_seq #(
    .DRAIN_CYC(D), .STOP_CYC(S), .RELOCK_CYC(R), .ODT_RESET(ODT0)
  ) i_odt_toggle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .cmd_hold(cmd_hold), .kclk_en(kclk_en), .odt_level(odt_level), .done(done)
  );

  task automatic check_now(input logic h, ce, o, d, input string tag);
    n_cmp++;
    if ({cmd_hold, kclk_en, odt_level, done} !== {h, ce, o, d}) begin
      n_bad++;
      $display("FAIL %s: hold/clk_en/odt/done actual %b%b%b%b expected %b%b%b%b",
               tag, cmd_hold, kclk_en, odt_level, done, h, ce, o, d);
    end
  endtask

  // monitor: compare one expected item a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check_now(e.hold, e.ce, e.odt, e.dn, e.tag);
      end
    end
  end

  // driver: inputs for the coming edge and the outputs expected after it
  task automatic step(input logic v, lv, h, ce, o, d, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v;
    req_level = lv;
    e.hold = h; e.ce = ce; e.odt = o; e.dn = d; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b1, model_odt, 1'b0, "R1 idle");
  endtask

  task automatic same_level();
    step(1'b1, model_odt, 1'b0, 1'b1, model_odt, 1'b1, "R6 same level done");
    step(1'b0, 1'b0, 1'b0, 1'b1, model_odt, 1'b0, "R6 R8 no hold after");
  endtask

  task automatic change(input logic lv, input bit noisy);
    logic cur;
    cur = model_odt;
    for (int j = 0; j < D + 2*S + R + 2; j++) begin
      logic v, l, h, ce, o, d;
      string tag;
      v = (j == 0) ? 1'b1 : (noisy && (j % 3 == 1));
      l = (j == 0) ? lv : logic'(j[1]);
      h = 1'b1; ce = 1'b1; o = cur; d = 1'b0;
      if (j < D) begin
        tag = "R2 drain";
      end else if (j < D + S + 1) begin
        ce = 1'b0; tag = "R3 stopped, old level";
      end else if (j < D + 2*S + 1) begin
        ce = 1'b0; o = lv; tag = "R4 stopped, new level";
      end else if (j < D + 2*S + R + 1) begin
        o = lv; tag = "R5 relock";
      end else begin
        h = 1'b0; o = lv; d = 1'b1; tag = "R5 R8 release with done";
      end
      if (noisy) tag = {tag, " R7 ignored requests"};
      if (lv) tag = {tag, " R9 enable"};
      step(v, l, h, ce, o, d, tag);
    end
    model_odt = lv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(1'b0, 1'b1, ODT0, 1'b0, "R1 during reset");
    rst = 1'b0;
    idle(3);
    same_level();
    change(1'b0, 1'b0);
    idle(2);
    same_level();
    change(1'b1, 1'b1);
    change(1'b0, 1'b1);
    idle(2);
    same_level();
    idle(3);
    @(negedge clk);
    @(negedge clk);
    n_cmp++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R5: queue left actual %0d expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule